// File: doc/BRIEF.md
# Multi-Lane Transmit Byte Striper

This block spreads a single upstream packet byte stream over a link of 1, 2, 4 or 8 lanes. Each output symbol time carries one byte per active lane, together with a flag that marks it as a control character. Bytes are gathered in an assembly register. When the last active lane is filled, the whole symbol time goes out at once. If a packet ends part-way through a symbol time and no new packet follows on the next clock, the unused lanes are padded. If a new packet does follow at once, it continues in the same symbol time.

Between packets the block sends logical idle on every active lane together. On request it inserts a skip ordered set, meaning one COM symbol time followed by three SKP symbol times, identical on every lane. While it does this, it raises a throttle toward the upstream buffer so that no packet bytes are accepted. The lane count comes from a configuration code that is captured while reset is held.

Top module: `lane_striper`

## Requirements
- R1: The active lane count N is taken from `cfg_lanes` while `rst` is high: code 0 gives 1 lane, 1 gives 2, 2 gives 4 and 3 gives 8. Changing `cfg_lanes` after reset has no effect. Lanes at index N and above always output data 00h with the K flag at 0.
- R2: Byte k of a packet that starts at a symbol-time boundary goes to lane (k mod N), with lane 0 in bits [7:0] of `out_data` and lane i in bits [8i+7:8i]. A symbol time is presented with `out_valid` high on the clock after the byte that fills its last active lane is accepted.
- R3: A packet that ends on a lane below N-1, with no packet start accepted on the next clock, is flushed on that next clock. The lanes after its last byte carry PAD (F7h, K=1), and the result appears one clock later.
- R4: A byte marked as packet start that is accepted on the clock right after a packet end on a lane below N-1 is placed on the next lane of the same symbol time, with no PAD in between.
- R5: A clock inside a packet on which no byte is accepted produces no symbol time (`out_valid` low), and no lane assignment is lost.
- R6: Between packets, on a clock with no accepted byte and no ordered set, every active lane carries IDL (7Ch, K=1), and never only some of them.
- R7: A `skp_req` pulse results in four consecutive symbol times on all active lanes with K=1: COM (BCh), then SKP (1Ch) three times.
- R8: A request made while a packet is open is held until the packet has ended and any PAD flush is done. No ordered-set symbol is emitted while a packet is open.
- R9: `in_throttle` is high from the clock after a request is registered (or after the packet end that releases it) through the clock that sends the last SKP. Bytes offered while it is high are ignored.
- R10: While `rst` is high, `out_valid` and `in_throttle` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; lane code captured while high |
| cfg_lanes | input | 2 | Lane-count code (0:1, 1:2, 2:4, 3:8) |
| in_valid | input | 1 | Upstream byte offered |
| in_data | input | 8 | Upstream byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_throttle | output | 1 | Upstream must hold its byte |
| skp_req | input | 1 | Pulse requesting one skip ordered set |
| out_valid | output | 1 | A symbol time is presented on the lanes |
| out_data | output | 8*MAX_LANES | Per-lane bytes, lane i in bits [8i+7:8i] |
| out_k | output | MAX_LANES | Per-lane control-character flag |

## Verification
The bench instantiates the block with MAX_LANES at its default of 8 and re-runs reset with every lane code, so the full-width, 4-lane, 2-lane and single-lane datapaths are all exercised on the same netlist. The 8-lane run shows a short packet padded across five lanes and confirms that the upper lanes stay at zero in narrow modes. The 4-lane table covers packing of back-to-back packets, an idle gap inside a packet, and a skip request that waits for a packet end while upstream bytes are held off. The 1-lane and 2-lane runs cover emitting on every byte, packing on the second lane, and ordered-set replication limited to the active lanes.

// File: rtl/lstripe_pkg.sv
package lstripe_pkg;

  // Control character codes driven with K=1
  localparam logic [7:0] KC_PAD = 8'hF7;
  localparam logic [7:0] KC_IDL = 8'h7C;
  localparam logic [7:0] KC_COM = 8'hBC;
  localparam logic [7:0] KC_SKP = 8'h1C;

  // Source of the symbol time being built this clock
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PKT  = 2'd1,
    SRC_IDLE = 2'd2,
    SRC_OS   = 2'd3
  } sym_src_e;

  // Lane count from a code, capped by the build's largest code
  function automatic logic [3:0] lane_count(input logic [1:0] code, input logic [1:0] cap);
    logic [1:0] e;
    e = (code > cap) ? cap : code;
    return 4'(4'd1 << e);
  endfunction

endpackage

// File: rtl/lstripe_cfg.sv
module lstripe_cfg #(
  parameter int MAX_LANES = 8,
  parameter int NW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_code,
  output logic [NW-1:0] n_lanes
);
  import lstripe_pkg::*;

  localparam int         LOG_MAX = $clog2(MAX_LANES);
  localparam logic [1:0] MAXC    = 2'(LOG_MAX);

  logic [NW-1:0] n_q;

  always_ff @(posedge clk) begin
    if (rst) n_q <= NW'(lane_count(cfg_code, MAXC));
  end

  assign n_lanes = n_q;

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(n_q));

  // R1
  cfg_pow2_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(n_q) == 1);

endmodule

// File: rtl/lstripe_asm.sv
module lstripe_asm #(
  parameter int MAX_LANES = 8,
  parameter int NW        = 4,
  parameter int CNTW      = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NW-1:0]          n_lanes,
  input  logic                   take,
  input  logic [7:0]             in_byte,
  input  logic                   in_eop,
  output logic                   emit,
  output logic [MAX_LANES*8-1:0] emit_data,
  output logic [MAX_LANES-1:0]   emit_pad,
  output logic                   boundary,
  output logic                   open_pkt
);
  import lstripe_pkg::*;

  logic [7:0]      slot_q [MAX_LANES];
  logic [CNTW-1:0] cnt_q;
  logic            pend_q;
  logic            open_q;

  logic last_lane;
  logic fill_last;
  logic flush;

  assign last_lane = ({1'b0, cnt_q} == (n_lanes - NW'(1)));
  assign fill_last = take && last_lane;
  assign flush     = !take && pend_q;
  assign emit      = fill_last || flush;
  assign boundary  = !open_q && !pend_q;
  assign open_pkt  = open_q;

  // Per-lane view of the symbol time that would leave this clock
  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic held;
    logic fresh;
    assign held  = (CNTW'(i) < cnt_q);
    assign fresh = take && (CNTW'(i) == cnt_q);
    assign emit_data[i*8 +: 8] = held ? slot_q[i] : (fresh ? in_byte : KC_PAD);
    assign emit_pad[i]         = !(held || fresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      open_q <= 1'b0;
    end else if (take) begin
      slot_q[cnt_q] <= in_byte;
      open_q        <= !in_eop;
      if (last_lane) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + CNTW'(1);
        pend_q <= in_eop;
      end
    end else if (pend_q) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end
  end

  // R2
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} < n_lanes);

  // R3
  pad_partial_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (cnt_q != '0) && !open_q);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (open_q && !take && !pend_q) |=> $stable(cnt_q));

endmodule

// File: rtl/lstripe_os.sv
module lstripe_os (
  input  logic clk,
  input  logic rst,
  input  logic os_req,
  input  logic boundary,
  input  logic open_pkt,
  output logic hold,
  output logic os_emit,
  output logic os_is_com
);
  logic       pend_q;
  logic       busy_q;
  logic [1:0] step_q;
  logic       start;

  assign start     = pend_q && boundary && !busy_q;
  assign hold      = busy_q || (pend_q && !open_pkt);
  assign os_emit   = start || busy_q;
  assign os_is_com = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      step_q <= 2'd0;
    end else begin
      if (os_req)     pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        step_q <= 2'd1;
      end else if (busy_q) begin
        step_q <= step_q + 2'd1;
        if (step_q == 2'd3) busy_q <= 1'b0;
      end
    end
  end

  // R8
  os_not_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    os_emit |-> !open_pkt);

  // R7
  com_then_skp_chk: assert property (@(posedge clk) disable iff (rst)
    os_is_com |=> os_emit && !os_is_com);

  // R9
  hold_over_os_chk: assert property (@(posedge clk) disable iff (rst)
    os_emit |-> hold);

endmodule

// File: rtl/lstripe_lanes.sv
module lstripe_lanes #(
  parameter int MAX_LANES = 8,
  parameter int NW        = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NW-1:0]           n_lanes,
  input  lstripe_pkg::sym_src_e   src,
  input  logic                    os_com,
  input  logic [MAX_LANES*8-1:0]  pkt_data,
  input  logic [MAX_LANES-1:0]    pkt_pad,
  output logic                    out_valid,
  output logic [MAX_LANES*8-1:0]  out_data,
  output logic [MAX_LANES-1:0]    out_k
);
  import lstripe_pkg::*;

  logic                   valid_q;
  logic [MAX_LANES*8-1:0] data_q;
  logic [MAX_LANES-1:0]   k_q;
  logic [MAX_LANES-1:0]   act;
  logic [MAX_LANES-1:0]   same_as0;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [7:0] d_nx;
    logic       k_nx;
    assign act[i] = (NW'(i) < n_lanes);

    always_comb begin
      d_nx = 8'h00;
      k_nx = 1'b0;
      if (act[i]) begin
        unique case (src)
          SRC_PKT:  begin d_nx = pkt_data[i*8 +: 8]; k_nx = pkt_pad[i]; end
          SRC_IDLE: begin d_nx = KC_IDL; k_nx = 1'b1; end
          SRC_OS:   begin d_nx = os_com ? KC_COM : KC_SKP; k_nx = 1'b1; end
          default:  begin d_nx = 8'h00; k_nx = 1'b0; end
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[i*8 +: 8] <= 8'h00;
        k_q[i]           <= 1'b0;
      end else begin
        data_q[i*8 +: 8] <= d_nx;
        k_q[i]           <= k_nx;
      end
    end

    assign same_as0[i] = !act[i] || ((k_q[i] == k_q[0]) && (data_q[i*8 +: 8] == data_q[7:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= (src != SRC_NONE);
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_k     = k_q;

  // R6
  idle_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && k_q[0] && data_q[7:0] == KC_IDL) |-> &same_as0);

  // R7
  os_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && k_q[0] && (data_q[7:0] == KC_COM || data_q[7:0] == KC_SKP)) |-> &same_as0);

  // R1
  unused_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (k_q & ~act) == '0);

endmodule

// File: rtl/lane_striper.sv
module lane_striper #(
  parameter int MAX_LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cfg_lanes,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  input  logic                   in_sop,
  input  logic                   in_eop,
  output logic                   in_throttle,
  input  logic                   skp_req,
  output logic                   out_valid,
  output logic [MAX_LANES*8-1:0] out_data,
  output logic [MAX_LANES-1:0]   out_k
);
  import lstripe_pkg::*;

  localparam int LOG_MAX = $clog2(MAX_LANES);
  localparam int CNTW    = LOG_MAX;
  localparam int NW      = LOG_MAX + 1;

  logic [NW-1:0]          n_lanes;
  logic                   take;
  logic                   hold;
  logic                   asm_emit;
  logic [MAX_LANES*8-1:0] asm_data;
  logic [MAX_LANES-1:0]   asm_pad;
  logic                   boundary;
  logic                   open_pkt;
  logic                   os_emit;
  logic                   os_com;
  sym_src_e               src;

  assign take        = in_valid && !hold;
  assign in_throttle = hold;

  always_comb begin
    if (os_emit)                 src = SRC_OS;
    else if (asm_emit)           src = SRC_PKT;
    else if (boundary && !take)  src = SRC_IDLE;
    else                         src = SRC_NONE;
  end

  lstripe_cfg #(.MAX_LANES(MAX_LANES), .NW(NW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_code(cfg_lanes), .n_lanes(n_lanes)
  );

  lstripe_asm #(.MAX_LANES(MAX_LANES), .NW(NW), .CNTW(CNTW)) u_asm (
    .clk(clk), .rst(rst), .n_lanes(n_lanes), .take(take),
    .in_byte(in_data), .in_eop(in_eop), .emit(asm_emit),
    .emit_data(asm_data), .emit_pad(asm_pad),
    .boundary(boundary), .open_pkt(open_pkt)
  );

  lstripe_os u_os (
    .clk(clk), .rst(rst), .os_req(skp_req), .boundary(boundary),
    .open_pkt(open_pkt), .hold(hold), .os_emit(os_emit), .os_is_com(os_com)
  );

  lstripe_lanes #(.MAX_LANES(MAX_LANES), .NW(NW)) u_lanes (
    .clk(clk), .rst(rst), .n_lanes(n_lanes), .src(src), .os_com(os_com),
    .pkt_data(asm_data), .pkt_pad(asm_pad),
    .out_valid(out_valid), .out_data(out_data), .out_k(out_k)
  );

  // R2
  sop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (take && boundary) |-> in_sop);

  // R9
  no_take_while_os_chk: assert property (@(posedge clk) disable iff (rst)
    os_emit |-> !take);

endmodule

// File: tb/lane_striper_bench.sv
module lane_striper_bench;

  localparam int ML = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      cfg_lanes = 2'd0;
  logic            in_valid = 1'b0;
  logic [7:0]      in_data = 8'h00;
  logic            in_sop = 1'b0;
  logic            in_eop = 1'b0;
  logic            skp_req = 1'b0;
  logic            in_throttle;
  logic            out_valid;
  logic [ML*8-1:0] out_data;
  logic [ML-1:0]   out_k;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  lane_striper #(.MAX_LANES(ML)) u_lane_striper (
    .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_throttle(in_throttle), .skp_req(skp_req),
    .out_valid(out_valid), .out_data(out_data), .out_k(out_k)
  );

  // One row per clock of the 4-lane run. Expected outputs are those seen
  // at the start of the row, caused by the previous row's inputs.
  typedef struct packed {
    logic        iv;
    logic        sop;
    logic        eop;
    logic [7:0]  d;
    logic        osr;
    logic        ev;
    logic        et;
    logic [3:0]  ek;
    logic [31:0] ed;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mkv(logic iv, logic sop, logic eop, logic [7:0] d, logic osr,
                               logic ev, logic et, logic [3:0] ek, logic [31:0] ed, logic [3:0] req);
    vec_t v;
    v.iv = iv; v.sop = sop; v.eop = eop; v.d = d; v.osr = osr;
    v.ev = ev; v.et = et; v.ek = ek; v.ed = ed; v.req = req;
    return v;
  endfunction

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    mkv(1,1,0,8'hA0,0, 1,0,4'hF,32'h7C7C7C7C, 4'd6),  // R6 idle after reset
    mkv(1,0,0,8'hA1,0, 0,0,4'h0,32'h0,        4'd2),
    mkv(1,0,0,8'hA2,0, 0,0,4'h0,32'h0,        4'd2),
    mkv(1,0,0,8'hA3,0, 0,0,4'h0,32'h0,        4'd2),
    mkv(1,1,1,8'hA4,0, 1,0,4'h0,32'hA3A2A1A0, 4'd2),  // R2 full symbol
    mkv(0,0,0,8'h00,0, 0,0,4'h0,32'h0,        4'd3),
    mkv(0,0,0,8'h00,0, 1,0,4'hE,32'hF7F7F7A4, 4'd3),  // R3 pad flush
    mkv(1,1,0,8'hB0,0, 1,0,4'hF,32'h7C7C7C7C, 4'd6),
    mkv(1,0,1,8'hB1,0, 0,0,4'h0,32'h0,        4'd4),
    mkv(1,1,0,8'hC0,0, 0,0,4'h0,32'h0,        4'd4),
    mkv(1,0,0,8'hC1,0, 0,0,4'h0,32'h0,        4'd4),
    mkv(1,0,0,8'hC2,1, 1,0,4'h0,32'hC1C0B1B0, 4'd4),  // R4 packed packets
    mkv(0,0,0,8'h00,0, 0,0,4'h0,32'h0,        4'd8),  // R8 no throttle mid-packet
    mkv(1,0,1,8'hC3,0, 0,0,4'h0,32'h0,        4'd5),  // R5 gap gave nothing
    mkv(1,1,0,8'hD0,0, 0,1,4'h0,32'h0,        4'd9),  // R9 D0 held off
    mkv(1,1,0,8'hD0,0, 1,1,4'hC,32'hF7F7C3C2, 4'd8),
    mkv(1,1,0,8'hD0,0, 1,1,4'hF,32'hBCBCBCBC, 4'd7),  // R7 COM
    mkv(1,1,0,8'hD0,0, 1,1,4'hF,32'h1C1C1C1C, 4'd7),
    mkv(1,1,0,8'hD0,0, 1,1,4'hF,32'h1C1C1C1C, 4'd7),
    mkv(1,1,0,8'hD0,0, 1,0,4'hF,32'h1C1C1C1C, 4'd9),
    mkv(1,0,1,8'hD1,0, 0,0,4'h0,32'h0,        4'd9),
    mkv(0,0,0,8'h00,0, 0,0,4'h0,32'h0,        4'd9),
    mkv(0,0,0,8'h00,0, 1,0,4'hC,32'hF7F7D1D0, 4'd9),  // R9 D0 once only
    mkv(0,0,0,8'h00,0, 1,0,4'hF,32'h7C7C7C7C, 4'd6)
  };

  task automatic drive(logic iv, logic sop, logic eop, logic [7:0] d, logic osr);
    in_valid = iv; in_sop = sop; in_eop = eop; in_data = d; skp_req = osr;
  endtask

  task automatic check_out(int req, logic ev, logic [ML*8-1:0] ed, logic [ML-1:0] ek);
    logic bad;
    checks++;
    bad = (out_valid !== ev) || (ev && ((out_data !== ed) || (out_k !== ek)));
    if (bad) begin
      fails++;
      $display("FAIL R%0d: valid=%0b data=%h k=%h expected valid=%0b data=%h k=%h",
               req, out_valid, out_data, out_k, ev, ed, ek);
    end
  endtask

  task automatic check_thr(int req, logic et);
    checks++;
    if (in_throttle !== et) begin
      fails++;
      $display("FAIL R%0d: in_throttle=%0b expected %0b", req, in_throttle, et);
    end
  endtask

  // Replicate one code on the first n lanes; K mask for those lanes
  function automatic logic [ML*8-1:0] rep(logic [7:0] c, int n);
    logic [ML*8-1:0] w = '0;
    for (int i = 0; i < n; i++) w[i*8 +: 8] = c;
    return w;
  endfunction

  function automatic logic [ML-1:0] kmask(int n);
    return ML'((1 << n) - 1);
  endfunction

  task automatic do_reset(logic [1:0] code);
    @(negedge clk);
    rst = 1'b1; cfg_lanes = code;
    drive(0, 0, 0, 8'h00, 0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check_out(10, 1'b0, '0, '0);
    check_thr(10, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // Table: 4-lane mode
    do_reset(2'd2);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_out(int'(VECS[i].req), VECS[i].ev, {32'h0, VECS[i].ed}, {4'h0, VECS[i].ek});
      drive(VECS[i].iv, VECS[i].sop, VECS[i].eop, VECS[i].d, VECS[i].osr);
      check_thr(int'(VECS[i].req), VECS[i].et);
    end

    // R1 / R2: single lane, cfg changed after reset must be ignored
    do_reset(2'd0);
    @(negedge clk);
    cfg_lanes = 2'd3;
    check_out(1, 1'b1, rep(8'h7C, 1), kmask(1));
    drive(1, 1, 0, 8'hE0, 0);
    @(negedge clk);
    check_out(2, 1'b1, 64'hE0, '0);
    drive(1, 0, 1, 8'hE1, 0);
    @(negedge clk);
    check_out(2, 1'b1, 64'hE1, '0);
    drive(0, 0, 0, 8'h00, 0);
    @(negedge clk);
    check_out(1, 1'b1, rep(8'h7C, 1), kmask(1));

    // R3: eight lanes, three-byte packet padded over five lanes
    do_reset(2'd3);
    @(negedge clk);
    check_out(6, 1'b1, rep(8'h7C, 8), kmask(8));
    drive(1, 1, 0, 8'hF0, 0);
    @(negedge clk);
    drive(1, 0, 0, 8'hF1, 0);
    @(negedge clk);
    drive(1, 0, 1, 8'hF2, 0);
    @(negedge clk);
    check_out(5, 1'b0, '0, '0);
    drive(0, 0, 0, 8'h00, 0);
    @(negedge clk);
    check_out(3, 1'b1, 64'hF7F7F7F7F7F2F1F0, 8'hF8);

    // R4 / R7 / R9: two lanes, packing then a skip ordered set
    do_reset(2'd1);
    @(negedge clk);
    check_out(6, 1'b1, rep(8'h7C, 2), kmask(2));
    drive(1, 1, 1, 8'h90, 0);
    @(negedge clk);
    check_out(4, 1'b0, '0, '0);
    drive(1, 1, 1, 8'h91, 0);
    @(negedge clk);
    check_out(4, 1'b1, 64'h9190, '0);
    drive(0, 0, 0, 8'h00, 1);
    @(negedge clk);
    check_out(6, 1'b1, rep(8'h7C, 2), kmask(2));
    check_thr(9, 1'b1);
    drive(0, 0, 0, 8'h00, 0);
    @(negedge clk);
    check_out(7, 1'b1, rep(8'hBC, 2), kmask(2));
    check_thr(9, 1'b1);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check_out(7, 1'b1, rep(8'h1C, 2), kmask(2));
      check_thr(9, (s < 2) ? 1'b1 : 1'b0);
    end
    @(negedge clk);
    check_out(6, 1'b1, rep(8'h7C, 2), kmask(2));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule